// File: doc/BRIEF.md
# Memory Sweep Test Master

This block drives an AXI4-Lite master port to test an attached memory end to end. It stays quiet until a one-cycle start request arrives. It then stores one word in every 64-bit location of the address space, ascending from address zero. When every store has been acknowledged, it fetches each location again in the same order and compares the returned word with the one it stored there. The stored value is a fixed function of the word index, so the expected value on readback is computed again rather than kept anywhere.

Three sticky outputs report the outcome. One says the whole sweep matched. One says a store was refused. One says a fetch was refused or returned the wrong word. The first failure stops the sweep, and the flags hold until reset. Only one transaction is in flight at any time. Addresses are 28 bits wide by default, which covers 256 MiB, and the data path is 64 bits wide. The address width is a parameter, so a bench can sweep a smaller space.

Top module: `memtest_gen`

## Requirements
- R1: After reset, pass_o, wr_err_o and rd_err_o are 0, and none of m_awvalid, m_wvalid or m_arvalid is asserted.
- R2: No transaction is issued until start_i is sampled high while the block is idle.
- R3: Word i is accessed at byte address 8*i. Both phases walk i from 0 up to 2^(ADDR_W-3)-1, one step at a time.
- R4: The word stored at index i is SEED ^ (i << 32) ^ ~i, where ~i is taken over ADDR_W-3 bits and zero-extended. The default SEED is 0x5A5AC3C30F0F9696. m_wstrb is all ones.
- R5: Every store response is received before the first read address is issued.
- R6: At most one transaction is outstanding. m_awvalid and m_wvalid rise together. Each valid, together with its payload, stays steady until its ready is seen.
- R7: If every fetched word matches and every response is OKAY (2'b00), pass_o rises and stays high until reset. A later start_i has no effect.
- R8: A store response other than OKAY sets wr_err_o. The sweep stops, and no further transactions are issued.
- R9: A fetch response other than OKAY sets rd_err_o and stops the sweep.
- R10: A fetched word that differs from the expected word sets rd_err_o and stops the sweep.
- R11: Reset clears all flags and returns the block to idle. A new start_i then runs a complete sweep again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts a sweep when idle |
| m_awaddr | output | ADDR_W | Write address |
| m_awprot | output | 3 | Write protection, fixed 0 |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arprot | output | 3 | Read protection, fixed 0 |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| pass_o | output | 1 | Sticky: the sweep completed with no error |
| wr_err_o | output | 1 | Sticky: a store failed |
| rd_err_o | output | 1 | Sticky: a fetch failed or mismatched |

## Verification
A flag is registered on the same clock edge as the response handshake that decides it, so it can be seen one edge after the memory model presents the response. The bench polls the flags on falling edges, with a bounded wait, rather than counting a fixed delay. Address, data, ordering and overlap are checked inside the memory model at each handshake edge. The results are read back after the run. Checks that something must not happen wait a fixed 40 to 60 cycles after the stimulus, which is long enough for a request to appear. They then compare the transaction counts against the values taken before the stimulus.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_ADDR,
    ST_WR_RESP,
    ST_RD_ADDR,
    ST_RD_RESP,
    ST_PASS,
    ST_FAIL
  } mt_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/memtest_rst_sync.sv
module memtest_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/memtest_word_cnt.sv
module memtest_word_cnt #(
  parameter int IW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);

  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en;

  always_comb begin
    idx_en = clr_i | inc_i;
    idx_d  = clr_i ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign last_o = &idx_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && last_o) |=> 1'b0) else $error("counter wrapped"); // R3

endmodule

// File: rtl/memtest_pattern.sv
module memtest_pattern #(
  parameter int          IW     = 25,
  parameter int          DATA_W = 64,
  parameter logic [63:0] SEED   = 64'h5A5A_C3C3_0F0F_9696
) (
  input  logic [IW-1:0]     idx_i,
  output logic [DATA_W-1:0] pat_o
);

  localparam int HALF = DATA_W / 2;

  logic [IW-1:0]     idx_n;
  logic [DATA_W-1:0] hi_part, lo_part;

  always_comb begin
    idx_n   = ~idx_i;
    hi_part = DATA_W'(idx_i) << HALF;
    lo_part = DATA_W'(idx_n);
    pat_o   = SEED[DATA_W-1:0] ^ hi_part ^ lo_part;
  end

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] pat_i,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              awvalid_o,
  input  logic              awready_i,
  output logic              wvalid_o,
  input  logic              wready_i,
  input  logic [1:0]        bresp_i,
  input  logic              bvalid_i,
  output logic              bready_o,
  output logic              arvalid_o,
  input  logic              arready_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [1:0]        rresp_i,
  input  logic              rvalid_i,
  output logic              rready_o,
  output logic              pass_o,
  output logic              wr_err_o,
  output logic              rd_err_o
);

  mt_state_e state_q, state_d;
  logic aw_done_q, aw_done_d, w_done_q, w_done_d;
  logic pass_q, pass_d, wr_err_q, wr_err_d, rd_err_q, rd_err_d;
  logic aw_fire, w_fire, rd_bad;

  always_comb begin
    awvalid_o = (state_q == ST_WR_ADDR) && !aw_done_q;
    wvalid_o  = (state_q == ST_WR_ADDR) && !w_done_q;
    bready_o  = (state_q == ST_WR_RESP);
    arvalid_o = (state_q == ST_RD_ADDR);
    rready_o  = (state_q == ST_RD_RESP);
    aw_fire   = awvalid_o && awready_i;
    w_fire    = wvalid_o && wready_i;
    rd_bad    = (rresp_i != RESP_OKAY) || (rdata_i != pat_i);
  end

  always_comb begin
    state_d   = state_q;
    aw_done_d = aw_done_q;
    w_done_d  = w_done_q;
    pass_d    = pass_q;
    wr_err_d  = wr_err_q;
    rd_err_d  = rd_err_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_WR_ADDR;
          cnt_clr_o = 1'b1;
        end
      end
      ST_WR_ADDR: begin
        if ((aw_done_q || aw_fire) && (w_done_q || w_fire)) begin
          state_d   = ST_WR_RESP;
          aw_done_d = 1'b0;
          w_done_d  = 1'b0;
        end else begin
          aw_done_d = aw_done_q | aw_fire;
          w_done_d  = w_done_q | w_fire;
        end
      end
      ST_WR_RESP: begin
        if (bvalid_i) begin
          if (bresp_i != RESP_OKAY) begin
            state_d  = ST_FAIL;
            wr_err_d = 1'b1;
          end else if (last_i) begin
            state_d   = ST_RD_ADDR;
            cnt_clr_o = 1'b1;
          end else begin
            state_d   = ST_WR_ADDR;
            cnt_inc_o = 1'b1;
          end
        end
      end
      ST_RD_ADDR: begin
        if (arready_i) state_d = ST_RD_RESP;
      end
      ST_RD_RESP: begin
        if (rvalid_i) begin
          if (rd_bad) begin
            state_d  = ST_FAIL;
            rd_err_d = 1'b1;
          end else if (last_i) begin
            state_d = ST_PASS;
            pass_d  = 1'b1;
          end else begin
            state_d   = ST_RD_ADDR;
            cnt_inc_o = 1'b1;
          end
        end
      end
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
      pass_q    <= 1'b0;
      wr_err_q  <= 1'b0;
      rd_err_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      aw_done_q <= aw_done_d;
      w_done_q  <= w_done_d;
      pass_q    <= pass_d;
      wr_err_q  <= wr_err_d;
      rd_err_q  <= rd_err_d;
    end
  end

  assign pass_o   = pass_q;
  assign wr_err_o = wr_err_q;
  assign rd_err_o = rd_err_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> !(awvalid_o || wvalid_o || arvalid_o)) else $error("request without start"); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !((awvalid_o || wvalid_o || bready_o) && (arvalid_o || rready_o))) else $error("overlap"); // R6
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid_o && !awready_i) |=> awvalid_o) else $error("awvalid dropped"); // R6
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid_o && !arready_i) |=> arvalid_o) else $error("arvalid dropped"); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_o, wr_err_o, rd_err_o})) else $error("flags clash"); // R8
  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |=> pass_o) else $error("pass dropped"); // R7
  AST_WERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |-> !(awvalid_o || wvalid_o || arvalid_o)) else $error("traffic after write error"); // R8
  AST_RERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> !(awvalid_o || arvalid_o)) else $error("traffic after read error"); // R9

endmodule

// File: rtl/memtest_gen.sv
module memtest_gen #(
  parameter int          ADDR_W = 28,
  parameter int          DATA_W = 64,
  parameter logic [63:0] SEED   = 64'h5A5A_C3C3_0F0F_9696
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [2:0]          m_awprot,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [2:0]          m_arprot,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic                pass_o,
  output logic                wr_err_o,
  output logic                rd_err_o
);

  localparam int BYTE_SH = $clog2(DATA_W / 8);
  localparam int IW      = ADDR_W - BYTE_SH;

  logic          rst_sync_n;
  logic          cnt_clr, cnt_inc, last;
  logic [IW-1:0] idx;
  logic [DATA_W-1:0] pat;
  logic [ADDR_W-1:0] word_addr;

  memtest_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  memtest_word_cnt #(.IW(IW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .idx_o(idx), .last_o(last)
  );

  memtest_pattern #(.IW(IW), .DATA_W(DATA_W), .SEED(SEED)) u_pat (
    .idx_i(idx), .pat_o(pat)
  );

  memtest_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .last_i(last), .pat_i(pat),
    .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc),
    .awvalid_o(m_awvalid), .awready_i(m_awready),
    .wvalid_o(m_wvalid), .wready_i(m_wready),
    .bresp_i(m_bresp), .bvalid_i(m_bvalid), .bready_o(m_bready),
    .arvalid_o(m_arvalid), .arready_i(m_arready),
    .rdata_i(m_rdata), .rresp_i(m_rresp), .rvalid_i(m_rvalid), .rready_o(m_rready),
    .pass_o(pass_o), .wr_err_o(wr_err_o), .rd_err_o(rd_err_o)
  );

  assign word_addr = {idx, {BYTE_SH{1'b0}}};
  assign m_awaddr  = word_addr;
  assign m_araddr  = word_addr;
  assign m_wdata   = pat;
  assign m_wstrb   = '1;
  assign m_awprot  = 3'b000;
  assign m_arprot  = 3'b000;

  AST_AW_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_awvalid && !m_awready) |=> $stable(m_awaddr)) else $error("awaddr moved"); // R6
  AST_W_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_wvalid && !m_wready) |=> $stable(m_wdata)) else $error("wdata moved"); // R6
  AST_AW_W_TOGETHER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(m_awvalid) |-> $rose(m_wvalid)) else $error("aw without w"); // R6

endmodule

// File: tb/test_memtest_gen.sv
`timescale 1ns/1ps
module test_memtest_gen;

  localparam int AW    = 9;
  localparam int DW    = 64;
  localparam int WORDS = 1 << (AW - 3);
  localparam logic [63:0] SEED = 64'h5A5A_C3C3_0F0F_9696;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [AW-1:0] awaddr, araddr;
  logic [2:0] awprot, arprot;
  logic awvalid, awready, wvalid, wready, bvalid, bready, arvalid, arready, rvalid, rready;
  logic [DW-1:0] wdata, rdata;
  logic [DW/8-1:0] wstrb;
  logic [1:0] bresp, rresp;
  logic pass, wr_err, rd_err;

  int total = 0, bad = 0;
  bit finished = 0;

  int inj_bresp = -1, inj_rresp = -1, inj_flip = -1;
  int wr_cnt, rd_cnt, addr_bad, data_bad, order_bad, overlap_bad, valid_seen;
  logic [DW-1:0] mem [WORDS];
  logic [3:0] tick;

  always #10 clk = ~clk;

  memtest_gen #(.ADDR_W(AW), .DATA_W(DW), .SEED(SEED)) i_memtest_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .m_awaddr(awaddr), .m_awprot(awprot), .m_awvalid(awvalid), .m_awready(awready),
    .m_wdata(wdata), .m_wstrb(wstrb), .m_wvalid(wvalid), .m_wready(wready),
    .m_bresp(bresp), .m_bvalid(bvalid), .m_bready(bready),
    .m_araddr(araddr), .m_arprot(arprot), .m_arvalid(arvalid), .m_arready(arready),
    .m_rdata(rdata), .m_rresp(rresp), .m_rvalid(rvalid), .m_rready(rready),
    .pass_o(pass), .wr_err_o(wr_err), .rd_err_o(rd_err)
  );

  function automatic logic [63:0] exp_pat(int i);
    logic [AW-4:0] n;
    n = ~i[AW-4:0];
    return SEED ^ (64'(i) << 32) ^ 64'(n);
  endfunction

  // AXI4-Lite memory model with variable ready latency and fault injection
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awready <= 0; wready <= 0; bvalid <= 0; bresp <= 0;
      arready <= 0; rvalid <= 0; rresp <= 0; rdata <= 0;
      wr_cnt <= 0; rd_cnt <= 0; addr_bad <= 0; data_bad <= 0;
      order_bad <= 0; overlap_bad <= 0; valid_seen <= 0; tick <= 0;
    end else begin
      tick <= tick + 1;
      awready <= 0; wready <= 0; arready <= 0;
      if (awvalid || wvalid || arvalid) valid_seen <= valid_seen + 1;
      if ((awvalid || wvalid) && (arvalid || bvalid || rvalid)) overlap_bad <= overlap_bad + 1;
      if (arvalid && (rvalid || bvalid)) overlap_bad <= overlap_bad + 1;
      if (awvalid && awready && wvalid && wready) begin
        if (awaddr != AW'(wr_cnt * 8)) addr_bad <= addr_bad + 1;
        if (wdata != exp_pat(wr_cnt) || wstrb != '1) data_bad <= data_bad + 1;
        if (rd_cnt != 0) order_bad <= order_bad + 1;
        mem[awaddr[AW-1:3]] <= wdata;
        bvalid <= 1;
        bresp  <= (wr_cnt == inj_bresp) ? 2'b10 : 2'b00;
        wr_cnt <= wr_cnt + 1;
      end else if (awvalid && wvalid && !awready && !bvalid && !tick[0]) begin
        awready <= 1; wready <= 1;
      end
      if (bvalid && bready) bvalid <= 0;
      if (arvalid && arready) begin
        if (araddr != AW'(rd_cnt * 8)) addr_bad <= addr_bad + 1;
        if (wr_cnt != WORDS) order_bad <= order_bad + 1;
        rvalid <= 1;
        rdata  <= mem[araddr[AW-1:3]] ^ ((rd_cnt == inj_flip) ? 64'h1 : 64'h0);
        rresp  <= (rd_cnt == inj_rresp) ? 2'b10 : 2'b00;
        rd_cnt <= rd_cnt + 1;
      end else if (arvalid && !arready && !rvalid && tick[1]) begin
        arready <= 1;
      end
      if (rvalid && rready) rvalid <= 0;
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    start = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (pass || wr_err || rd_err) break;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk({pass, wr_err, rd_err} == 3'b000, "R1 flags", {pass, wr_err, rd_err}, 0);
    chk(!(awvalid || wvalid || arvalid), "R1 valids", {awvalid, wvalid, arvalid}, 0);
  endtask

  task automatic t_no_start();
    do_reset();
    repeat (50) @(negedge clk);
    chk(valid_seen == 0, "R2 no request", valid_seen, 0);
  endtask

  task automatic t_full_pass();
    int w;
    do_reset();
    pulse_start();
    wait_end();
    chk(pass && !wr_err && !rd_err, "R7 pass", {pass, wr_err, rd_err}, 3'b100);
    chk(addr_bad == 0, "R3 addresses", addr_bad, 0);
    chk(wr_cnt == WORDS && rd_cnt == WORDS, "R3 coverage", wr_cnt, WORDS);
    chk(data_bad == 0, "R4 pattern", data_bad, 0);
    chk(order_bad == 0, "R5 order", order_bad, 0);
    chk(overlap_bad == 0, "R6 single outstanding", overlap_bad, 0);
    w = wr_cnt;
    pulse_start();
    repeat (40) @(negedge clk);
    chk(pass && wr_cnt == w, "R7 sticky, start ignored", wr_cnt, w);
  endtask

  task automatic t_wr_err();
    int w;
    inj_bresp = 5;
    do_reset();
    pulse_start();
    wait_end();
    chk(wr_err && !pass && !rd_err, "R8 write flag", {pass, wr_err, rd_err}, 3'b010);
    w = wr_cnt;
    repeat (60) @(negedge clk);
    chk(wr_cnt == 6 && wr_cnt == w && rd_cnt == 0, "R8 stop", wr_cnt, 6);
    inj_bresp = -1;
  endtask

  task automatic t_rd_resp_err();
    inj_rresp = 7;
    do_reset();
    pulse_start();
    wait_end();
    chk(rd_err && !pass && !wr_err, "R9 read resp flag", {pass, wr_err, rd_err}, 3'b001);
    repeat (60) @(negedge clk);
    chk(rd_cnt == 8, "R9 stop", rd_cnt, 8);
    inj_rresp = -1;
  endtask

  task automatic t_mismatch();
    inj_flip = WORDS - 1;
    do_reset();
    pulse_start();
    wait_end();
    chk(rd_err && !pass && !wr_err, "R10 mismatch flag", {pass, wr_err, rd_err}, 3'b001);
    chk(rd_cnt == WORDS, "R10 reads", rd_cnt, WORDS);
    inj_flip = -1;
  endtask

  task automatic t_reset_rerun();
    do_reset();
    pulse_start();
    wait_end();
    do_reset();
    chk({pass, wr_err, rd_err} == 3'b000, "R11 cleared", {pass, wr_err, rd_err}, 0);
    pulse_start();
    wait_end();
    chk(pass && wr_cnt == WORDS, "R11 rerun", wr_cnt, WORDS);
  endtask

  initial begin
    rst_n = 0; start = 0;
    t_reset_state();
    t_no_start();
    t_full_pass();
    t_wr_err();
    t_rd_resp_err();
    t_mismatch();
    t_reset_rerun();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule